// File: doc/BRIEF.md
# Configuration Memory CRC Scanner with Serial Readout

This block guards a small on-chip configuration memory against silent bit flips. A scan engine, clocked by a free-running check clock, walks the memory one word per cycle, folds every word into a 32-bit CRC and, at the end of each pass, compares the result with a reference value held in the block. A mismatch raises an error flag, and every finished pass produces a single-cycle completion pulse. The memory itself is a plain register array with a test port, so a test can load an image or invert chosen bits.

Core logic running on an unrelated user clock can inspect either the stored reference or the most recent signature. A 32-bit shift register in the user domain loads one of the two in parallel, then presents it one bit per user clock, most significant bit first. The reference and the signature reach the user domain through a toggle-qualified two-flop capture, so the readout always sees a complete value.

Top module: `crc_scan_monitor`

## Requirements
- R1: On a rising `usr_clk` edge with `shift_nload` = 0 the readout register loads the stored reference when `src_sel` = 0 and the latest signature when `src_sel` = 1; `ser_out` is always bit 31 of that register.
- R2: On a rising `usr_clk` edge with `shift_nload` = 1 the readout register moves one place toward bit 31 and a 0 enters bit 0, so a load followed by 31 shifts shows all 32 bits MSB first, and one further shift gives `ser_out` = 0.
- R3: `src_sel` has no effect while `shift_nload` = 1.
- R4: The signature is CRC-32 with polynomial 0x04C11DB7, not bit-reflected, register preset to 0xFFFFFFFF at the start of each pass, no final inversion, words taken from address 0 upward and each word fed MSB first.
- R5: `cycle_done` is high for exactly one `chk_clk` cycle at the end of each pass, and passes repeat every DEPTH `chk_clk` cycles.
- R6: `err_flag` changes only together with `cycle_done`: it becomes 1 when the finished signature differs from the reference and 0 when it matches, and holds its value between passes.
- R7: While `eng_clr` = 1 on a `chk_clk` edge, `err_flag` and `cycle_done` go to 0 and the next pass restarts at address 0, its `cycle_done` arriving DEPTH edges after `eng_clr` returns to 0; `ref_we` writes the reference only while `eng_clr` = 1 and is ignored otherwise.
- R8: The test port writes `tp_wdata` into word `tp_addr` when `tp_flip` = 0 and XORs `tp_wdata` into that word when `tp_flip` = 1.
- R9: After reset `err_flag`, `cycle_done` and `ser_out` are 0.
- R10: A signature completed at a `cycle_done` pulse, and a reference written under `eng_clr`, can be loaded into the readout register 8 `usr_clk` cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| chk_clk | input | 1 | Check-engine clock |
| chk_rst_n | input | 1 | Asynchronous active-low reset, check domain |
| usr_clk | input | 1 | User readout clock |
| usr_rst_n | input | 1 | Asynchronous active-low reset, user domain |
| eng_clr | input | 1 | Synchronous engine clear; enables reference writes |
| ref_we | input | 1 | Reference write strobe (check domain) |
| ref_wdata | input | 32 | Reference value to store |
| tp_we | input | 1 | Test port write strobe (check domain) |
| tp_flip | input | 1 | 0: overwrite word, 1: XOR into word |
| tp_addr | input | AW = log2(DEPTH) | Test port word address |
| tp_wdata | input | WORD_W | Test port data or flip mask |
| err_flag | output | 1 | Signature mismatch flag (check domain) |
| cycle_done | output | 1 | One-cycle pulse per finished pass (check domain) |
| shift_nload | input | 1 | 0: parallel load, 1: shift (user domain) |
| src_sel | input | 1 | Load source: 0 reference, 1 signature |
| ser_out | output | 1 | Serial readout bit (user domain) |

## Verification
The hardest state to reach is a pass whose signature differs from the reference by a single bit that was flipped at a known point in the scan, because the engine reads memory continuously and a flip landing mid-pass gives a mixed result. The bench places the flip on the first edge after a completion pulse, at an address the engine has not yet reached, so the very next pulse must raise the flag and the signature read back must equal the model CRC of the altered image. A second hard case is proving that a reference write outside the clear window is ignored; the bench shows it both through the flag staying set and through a serial readback of the reference.

// File: rtl/crc_scan_pkg.sv
package crc_scan_pkg;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [CRC_W-1:0] CRC_PRESET = 32'hFFFF_FFFF;
  typedef logic [CRC_W-1:0] crc_t;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pipe_q <= 2'b00;
    else         pipe_q <= {pipe_q[0], 1'b1};
  end

  assign srst_n = pipe_q[1];
endmodule

// File: rtl/cfg_mem.sv
module cfg_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tp_we,
  input  logic          tp_flip,
  input  logic [AW-1:0] tp_addr,
  input  logic [W-1:0]  tp_wdata,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic         hit;
    logic [W-1:0] word_d;
    logic [W-1:0] word_q;

    always_comb begin
      hit    = tp_we && (tp_addr == AW'(g));
      word_d = tp_flip ? (word_q ^ tp_wdata) : tp_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= word_d;
    end

    assign words[g] = word_q;
  end

  assign rd_data = words[rd_addr];
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_scan_pkg::*;
#(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ref_we,
  input  crc_t          ref_wdata,
  output logic [AW-1:0] rd_addr,
  input  logic [W-1:0]  rd_data,
  output crc_t          sig_o,
  output crc_t          ref_o,
  output logic          done_o,
  output logic          err_o,
  output logic          xfer_o
);
  logic [AW-1:0] addr_q, addr_d;
  crc_t          acc_q, acc_d;
  crc_t          sig_q, ref_q;
  logic          err_q, err_d;
  logic          done_q, done_d;
  logic          xfer_q, xfer_d;
  logic          last, sig_en, ref_en;
  crc_t          crc_in, crc_nx;
  logic          fb;

  // Fold one memory word into the running CRC, MSB first.
  always_comb begin
    crc_in = (addr_q == '0) ? CRC_PRESET : acc_q;
    crc_nx = crc_in;
    fb     = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      fb     = crc_nx[CRC_W-1] ^ rd_data[i];
      crc_nx = {crc_nx[CRC_W-2:0], 1'b0};
      if (fb) crc_nx = crc_nx ^ CRC_POLY;
    end
  end

  always_comb begin
    last   = (addr_q == AW'(DEPTH - 1));
    addr_d = (clr || last) ? '0 : addr_q + AW'(1);
    acc_d  = crc_nx;
    sig_en = !clr && last;
    ref_en = clr && ref_we;
    done_d = sig_en;
    xfer_d = sig_en || ref_en;
    if (clr)       err_d = 1'b0;
    else if (last) err_d = (crc_nx != ref_q);
    else           err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      acc_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      acc_q  <= acc_d;
      err_q  <= err_d;
      done_q <= done_d;
      xfer_q <= xfer_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig_q <= '0;
    else if (sig_en) sig_q <= crc_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ref_q <= '0;
    else if (ref_en) ref_q <= ref_wdata;
  end

  assign rd_addr = addr_q;
  assign sig_o   = sig_q;
  assign ref_o   = ref_q;
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign xfer_o  = xfer_q;
endmodule

// File: rtl/cdc_word_xfer.sv
module cdc_word_xfer #(
  parameter int W = 64
) (
  input  logic         src_clk,
  input  logic         src_rst_n,
  input  logic         src_pulse,
  input  logic [W-1:0] src_data,
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  output logic [W-1:0] dst_data
);
  logic         tgl_q, tgl_d;
  logic [2:0]   sync_q;
  logic         cap_en;
  logic [W-1:0] data_q;

  assign tgl_d = tgl_q ^ src_pulse;

  always_ff @(posedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) tgl_q <= 1'b0;
    else            tgl_q <= tgl_d;
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) sync_q <= 3'b000;
    else            sync_q <= {sync_q[1:0], tgl_q};
  end

  assign cap_en = sync_q[2] ^ sync_q[1];

  // src_data is held steady by the source from its update edge onward.
  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n)  data_q <= '0;
    else if (cap_en) data_q <= src_data;
  end

  assign dst_data = data_q;
endmodule

// File: rtl/readout_sreg.sv
module readout_sreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_nload,
  input  logic         src_sel,
  input  logic [W-1:0] ref_word,
  input  logic [W-1:0] sig_word,
  output logic [W-1:0] q,
  output logic         ser_out
);
  logic [W-1:0] q_r, q_d;

  always_comb begin
    if (shift_nload) q_d = {q_r[W-2:0], 1'b0};
    else             q_d = src_sel ? sig_word : ref_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_d;
  end

  assign q       = q_r;
  assign ser_out = q_r[W-1];
endmodule

// File: rtl/crc_scan_monitor.sv
module crc_scan_monitor
  import crc_scan_pkg::*;
#(
  parameter  int WORD_W = 32,
  parameter  int DEPTH  = 16,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              chk_clk,
  input  logic              chk_rst_n,
  input  logic              usr_clk,
  input  logic              usr_rst_n,
  input  logic              eng_clr,
  input  logic              ref_we,
  input  logic [CRC_W-1:0]  ref_wdata,
  input  logic              tp_we,
  input  logic              tp_flip,
  input  logic [AW-1:0]     tp_addr,
  input  logic [WORD_W-1:0] tp_wdata,
  output logic              err_flag,
  output logic              cycle_done,
  input  logic              shift_nload,
  input  logic              src_sel,
  output logic              ser_out
);
  localparam int XW = 2 * CRC_W;

  logic              chk_rst_s_n, usr_rst_s_n;
  logic [AW-1:0]     rd_addr;
  logic [WORD_W-1:0] rd_data;
  crc_t              sig_w, ref_w, usr_sig_w, usr_ref_w;
  logic              xfer_w;
  logic [XW-1:0]     usr_bundle;
  logic [CRC_W-1:0]  rd_q;

  rst_sync u_chk_rst (.clk(chk_clk), .arst_n(chk_rst_n), .srst_n(chk_rst_s_n));
  rst_sync u_usr_rst (.clk(usr_clk), .arst_n(usr_rst_n), .srst_n(usr_rst_s_n));

  cfg_mem #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(chk_clk), .rst_n(chk_rst_s_n),
    .tp_we(tp_we), .tp_flip(tp_flip), .tp_addr(tp_addr), .tp_wdata(tp_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  crc_engine #(.W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_eng (
    .clk(chk_clk), .rst_n(chk_rst_s_n), .clr(eng_clr),
    .ref_we(ref_we), .ref_wdata(ref_wdata),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .sig_o(sig_w), .ref_o(ref_w), .done_o(cycle_done), .err_o(err_flag),
    .xfer_o(xfer_w)
  );

  cdc_word_xfer #(.W(XW)) u_xfer (
    .src_clk(chk_clk), .src_rst_n(chk_rst_s_n), .src_pulse(xfer_w),
    .src_data({ref_w, sig_w}),
    .dst_clk(usr_clk), .dst_rst_n(usr_rst_s_n), .dst_data(usr_bundle)
  );

  assign usr_ref_w = usr_bundle[XW-1:CRC_W];
  assign usr_sig_w = usr_bundle[CRC_W-1:0];

  readout_sreg #(.W(CRC_W)) u_rd (
    .clk(usr_clk), .rst_n(usr_rst_s_n),
    .shift_nload(shift_nload), .src_sel(src_sel),
    .ref_word(usr_ref_w), .sig_word(usr_sig_w),
    .q(rd_q), .ser_out(ser_out)
  );
endmodule

// File: rtl/crc_scan_monitor_chk.sv
module crc_scan_monitor_chk #(
  parameter int W = 32
) (
  input logic         chk_clk,
  input logic         chk_rst_n,
  input logic         usr_clk,
  input logic         usr_rst_n,
  input logic         eng_clr,
  input logic         cycle_done,
  input logic         err_flag,
  input logic         shift_nload,
  input logic         src_sel,
  input logic         ser_out,
  input logic [W-1:0] rd_q,
  input logic [W-1:0] usr_ref,
  input logic [W-1:0] usr_sig
);
  // R5
  done_single_chk: assert property (@(posedge chk_clk) disable iff (!chk_rst_n)
    cycle_done |=> !cycle_done);

  // R6
  err_moves_with_done_chk: assert property (@(posedge chk_clk) disable iff (!chk_rst_n)
    !$stable(err_flag) |-> (cycle_done || $past(eng_clr)));

  // R7
  clear_quiets_chk: assert property (@(posedge chk_clk) disable iff (!chk_rst_n)
    eng_clr |=> (!cycle_done && !err_flag));

  // R1
  load_ref_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    (!shift_nload && !src_sel) |=> (rd_q == $past(usr_ref)));

  // R1
  load_sig_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    (!shift_nload && src_sel) |=> (rd_q == $past(usr_sig)));

  // R2
  shift_bit_chk: assert property (@(posedge usr_clk) disable iff (!usr_rst_n)
    shift_nload |=> (ser_out == $past(rd_q[W-2]) && !rd_q[0]));
endmodule

bind crc_scan_monitor crc_scan_monitor_chk #(.W(crc_scan_pkg::CRC_W)) u_chk (
  .chk_clk(chk_clk), .chk_rst_n(chk_rst_s_n),
  .usr_clk(usr_clk), .usr_rst_n(usr_rst_s_n),
  .eng_clr(eng_clr), .cycle_done(cycle_done), .err_flag(err_flag),
  .shift_nload(shift_nload), .src_sel(src_sel), .ser_out(ser_out),
  .rd_q(rd_q), .usr_ref(usr_ref_w), .usr_sig(usr_sig_w)
);

// File: tb/crc_scan_monitor_tb.sv
module crc_scan_monitor_tb;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic        chk_clk = 1'b0, usr_clk = 1'b0;
  logic        chk_rst_n, usr_rst_n;
  logic        eng_clr, ref_we, tp_we, tp_flip, shift_nload, src_sel;
  logic [31:0] ref_wdata, tp_wdata;
  logic [AW-1:0] tp_addr;
  logic        err_flag, cycle_done, ser_out;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] mimg [DEPTH];

  always #5 chk_clk = ~chk_clk;
  always #7 usr_clk = ~usr_clk;

  crc_scan_monitor u_dut (
    .chk_clk(chk_clk), .chk_rst_n(chk_rst_n), .usr_clk(usr_clk), .usr_rst_n(usr_rst_n),
    .eng_clr(eng_clr), .ref_we(ref_we), .ref_wdata(ref_wdata),
    .tp_we(tp_we), .tp_flip(tp_flip), .tp_addr(tp_addr), .tp_wdata(tp_wdata),
    .err_flag(err_flag), .cycle_done(cycle_done),
    .shift_nload(shift_nload), .src_sel(src_sel), .ser_out(ser_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // CRC-32, poly 0x04C11DB7, preset all ones, MSB first, no reflection.
  function automatic logic [31:0] model_crc();
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int a = 0; a < DEPTH; a++)
      for (int i = 31; i >= 0; i--) begin
        logic fb = c[31] ^ mimg[a][i];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C1_1DB7;
      end
    return c;
  endfunction

  task automatic wait_done();
    int n = 0;
    do begin
      @(negedge chk_clk);
      n++;
    end while (!cycle_done && n < 4 * DEPTH);
  endtask

  task automatic read_word(input bit src, output logic [31:0] w, output logic tail);
    @(negedge usr_clk); shift_nload = 1'b0; src_sel = src;
    @(negedge usr_clk); w[31] = ser_out; shift_nload = 1'b1;
    for (int i = 30; i >= 0; i--) begin
      src_sel = ~src_sel;
      @(negedge usr_clk); w[i] = ser_out;
    end
    @(negedge usr_clk); tail = ser_out;
  endtask

  task automatic t_reset();
    chk_rst_n = 1'b0; usr_rst_n = 1'b0;
    eng_clr = 1'b1; ref_we = 1'b0; ref_wdata = '0;
    tp_we = 1'b0; tp_flip = 1'b0; tp_addr = '0; tp_wdata = '0;
    shift_nload = 1'b1; src_sel = 1'b0;
    repeat (5) @(negedge chk_clk);
    chk_rst_n = 1'b1; usr_rst_n = 1'b1;
    repeat (4) @(negedge usr_clk);
    check("R9 err_flag after reset", {31'b0, err_flag}, 32'd0);
    check("R9 cycle_done after reset", {31'b0, cycle_done}, 32'd0);
    check("R9 ser_out after reset", {31'b0, ser_out}, 32'd0);
  endtask

  task automatic t_load_clean();
    logic [31:0] w; logic tail;
    for (int a = 0; a < DEPTH; a++) begin
      mimg[a] = 32'h1234_5678 ^ (a * 32'h9E37_79B9);
      @(negedge chk_clk); tp_we = 1'b1; tp_flip = 1'b0; tp_addr = AW'(a); tp_wdata = mimg[a];
    end
    @(negedge chk_clk); tp_we = 1'b0; ref_we = 1'b1; ref_wdata = model_crc();
    @(negedge chk_clk); ref_we = 1'b0;
    repeat (8) @(negedge usr_clk);
    read_word(1'b0, w, tail);
    check("R10 R1 reference readback after write", w, model_crc());
  endtask

  task automatic t_run_clean();
    bit early = 1'b0, errs = 1'b0;
    @(negedge chk_clk); eng_clr = 1'b0;
    for (int k = 1; k < DEPTH; k++) begin
      @(negedge chk_clk);
      if (cycle_done) early = 1'b1;
      if (err_flag) errs = 1'b1;
    end
    @(negedge chk_clk);
    check("R7 no pulse before DEPTH edges after release", {31'b0, early}, 32'd0);
    check("R7 pulse DEPTH edges after release", {31'b0, cycle_done}, 32'd1);
    early = 1'b0;
    for (int k = 1; k < DEPTH; k++) begin
      @(negedge chk_clk);
      if (cycle_done) early = 1'b1;
      if (err_flag) errs = 1'b1;
    end
    @(negedge chk_clk);
    check("R5 single-cycle pulse, period DEPTH", {30'b0, early, cycle_done}, 32'd1);
    check("R4 R6 matching image keeps flag low", {31'b0, errs | err_flag}, 32'd0);
  endtask

  task automatic t_inject();
    bit early_err = 1'b0;
    logic [31:0] w; logic tail;
    // Called at the negedge showing cycle_done; address 3 not yet scanned.
    tp_we = 1'b1; tp_flip = 1'b1; tp_addr = AW'(3); tp_wdata = 32'h0000_0080;
    mimg[3] = mimg[3] ^ 32'h0000_0080;
    @(negedge chk_clk); tp_we = 1'b0;
    for (int k = 2; k < DEPTH; k++) begin
      @(negedge chk_clk);
      if (err_flag) early_err = 1'b1;
    end
    @(negedge chk_clk);
    check("R6 flag held low until pass ends", {31'b0, early_err}, 32'd0);
    check("R8 R6 flipped bit raises flag at next pulse", {30'b0, cycle_done, err_flag}, 32'd3);
    repeat (8) @(negedge usr_clk);
    read_word(1'b1, w, tail);
    check("R4 R10 R3 signature readback of altered image", w, model_crc());
    check("R2 zero after 32 shifts", {31'b0, tail}, 32'd0);
    read_word(1'b0, w, tail);
    mimg[3] = mimg[3] ^ 32'h0000_0080;
    check("R1 reference readback unchanged", w, model_crc());
    mimg[3] = mimg[3] ^ 32'h0000_0080;
    wait_done();
    check("R6 flag stays set on repeat mismatch", {30'b0, cycle_done, err_flag}, 32'd3);
  endtask

  task automatic t_restore();
    @(negedge chk_clk); tp_we = 1'b1; tp_flip = 1'b1; tp_addr = AW'(3); tp_wdata = 32'h0000_0080;
    mimg[3] = mimg[3] ^ 32'h0000_0080;
    @(negedge chk_clk); tp_we = 1'b0;
    wait_done();
    wait_done();
    check("R8 R6 second flip restores, flag clears", {30'b0, cycle_done, err_flag}, 32'd2);
  endtask

  task automatic t_clear();
    logic [31:0] good, bad, w; logic tail;
    bit early = 1'b0;
    good = model_crc(); bad = good ^ 32'h0000_0001;
    @(negedge chk_clk); eng_clr = 1'b1; ref_we = 1'b1; ref_wdata = bad;
    @(negedge chk_clk); ref_we = 1'b0; eng_clr = 1'b0;
    wait_done();
    check("R6 wrong reference raises flag", {31'b0, err_flag}, 32'd1);
    @(negedge chk_clk); ref_we = 1'b1; ref_wdata = good;
    @(negedge chk_clk); ref_we = 1'b0;
    wait_done();
    check("R7 write outside clear ignored (flag)", {31'b0, err_flag}, 32'd1);
    repeat (8) @(negedge usr_clk);
    read_word(1'b0, w, tail);
    check("R7 write outside clear ignored (readback)", w, bad);
    @(negedge chk_clk); eng_clr = 1'b1;
    @(negedge chk_clk); eng_clr = 1'b0;
    check("R7 clear drops flag and pulse", {30'b0, cycle_done, err_flag}, 32'd0);
    for (int k = 1; k < DEPTH; k++) begin
      @(negedge chk_clk);
      if (cycle_done) early = 1'b1;
    end
    @(negedge chk_clk);
    check("R7 restart at address 0 after clear", {30'b0, early, cycle_done}, 32'd1);
    check("R6 mismatch seen again after restart", {31'b0, err_flag}, 32'd1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_clean();
    t_run_clean();
    t_inject();
    t_restore();
    t_clear();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule